// File: doc/BRIEF.md
# Segment Uop Split Sequencer

This block takes one decoded vector segment memory instruction and expands it into an ordered stream of micro-operations. The instruction arrives through a valid/ready handshake. It carries the addressing mode, the field count, the data and index register group multipliers, and four register numbers: the destination group, the scalar base, the scalar stride and the index vector group. The block then presents one uop at a time on a second valid/ready handshake.

Each uop carries its sequence index and its destination register. It also carries a base register and an offset-source register, and each of these two has a flag that says whether the field is meaningful. Uops leave in strict order, starting from the register group of the first field. The final uop is flagged. A new instruction is accepted only after that final uop has been taken.

Encodings used throughout:
- The mode is 2 bits: 0 is unit-stride, 1 is strided, 2 is indexed, and 3 behaves as strided.
- The field count is given as nf−1 in 3 bits.
- Each multiplier is given as its base-2 logarithm in 2 bits, so 0 to 3 means 1, 2, 4 or 8.

Top module: `segUopSplitter`

## Requirements
- R1: During and right after reset, `uopValid` is 0 and `instReady` is 1.
- R2: `instReady` is high only when no uops are pending. An instruction is taken on the edge where `instValid` and `instReady` are both high. In the next cycle `uopValid` is 1 and `uopIdx` is 0. While uops are pending, `instValid` and the instruction fields have no effect.
- R3: With mode 0, 1 or 3, the instruction produces exactly (2^emulLog2) × nf uops.
- R4: With mode 2, the instruction produces exactly max((2^lmulLog2) × nf, 2^emulLog2) uops.
- R5: The uop with index i has `uopDest` = (vd + i) mod 32.
- R6: With mode 0, 1 or 3, every uop has `uopBaseReg` = rs1 and `uopOffReg` = rs2, and both valid flags are 1.
- R7: With mode 2, uop 0 has `uopBaseReg` = rs1 with its flag set. Every later uop has the base flag 0 and `uopBaseReg` = 0.
- R8: With mode 2, a uop with index i < 2^emulLog2 has `uopOffReg` = (vs2 + i) mod 32 with its flag set. Any later uop has the offset flag 0 and `uopOffReg` = 0.
- R9: While `uopValid` is 1 and `uopReady` is 0, every uop output holds its value into the next cycle.
- R10: `uopLast` is 1 only on the final uop. In the cycle after the final uop is taken, `uopValid` is 0 and `instReady` is 1.
- R11: Uop indices start at 0 and rise by exactly one on each transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction offered |
| instReady | output | 1 | Block can take an instruction |
| instMode | input | 2 | Addressing mode |
| instNfm1 | input | NF_W (3) | Field count minus one |
| instLmulLog2 | input | MUL_W (2) | log2 of the data group multiplier |
| instEmulLog2 | input | MUL_W (2) | log2 of the index/effective group multiplier |
| instVd | input | REG_W (5) | Destination group base register |
| instRs1 | input | REG_W (5) | Scalar base address register |
| instRs2 | input | REG_W (5) | Scalar stride register |
| instVs2 | input | REG_W (5) | Index vector group base register |
| uopValid | output | 1 | Uop presented |
| uopReady | input | 1 | Consumer takes the uop |
| uopIdx | output | IDX_W (6) | Uop sequence index |
| uopDest | output | REG_W (5) | Destination register |
| uopBaseReg | output | REG_W (5) | Base register, 0 when not meaningful |
| uopBaseValid | output | 1 | Base field meaningful |
| uopOffReg | output | REG_W (5) | Offset-source register, 0 when not meaningful |
| uopOffValid | output | 1 | Offset field meaningful |
| uopLast | output | 1 | Final uop of the instruction |

## Verification
The bench builds the block with its defaults: 5-bit register numbers, a 3-bit field count and 2-bit multiplier logs. With these values the extreme of 8 fields times a multiplier of 8 can be reached, which gives the 64-uop sequence that fills the full index counter. The defaults also bring register-number wraparound past 31 into reach for both the destination and the index registers. Indexed cases cover each operand of the maximum: the data-group product winning, the index multiplier winning, and a tie. Consumer stalls and ignored instruction offers are mixed into the uop stream.

// File: rtl/segSplitPkg.sv
package segSplitPkg;

  typedef enum logic [1:0] {
    MODE_UNIT    = 2'd0,
    MODE_STRIDED = 2'd1,
    MODE_INDEXED = 2'd2,
    MODE_RSVD    = 2'd3
  } splitMode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EMIT = 1'b1
  } splitState_e;

  typedef struct packed {
    logic load;
    logic advance;
  } splitStrobes_t;

endpackage

// File: rtl/segSplitCtrl.sv
module segSplitCtrl
  import segSplitPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          instValid,
  input  logic          uopReady,
  input  logic          isLast,
  output logic          instReady,
  output logic          uopValid,
  output splitStrobes_t strobes
);

  splitState_e state, stateNext;

  always_comb begin
    stateNext       = state;
    strobes.load    = 1'b0;
    strobes.advance = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (instValid) begin
          strobes.load = 1'b1;
          stateNext    = ST_EMIT;
        end
      end
      ST_EMIT: begin
        if (uopReady) begin
          if (isLast) stateNext = ST_IDLE;
          else        strobes.advance = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign instReady = (state == ST_IDLE);
  assign uopValid  = (state == ST_EMIT);

endmodule

// File: rtl/segSplitDatapath.sv
module segSplitDatapath
  import segSplitPkg::*;
#(
  parameter int REG_W = 5,
  parameter int NF_W  = 3,
  parameter int MUL_W = 2,
  localparam int CNT_W = NF_W + 1 + (2**MUL_W - 1),
  localparam int IDX_W = CNT_W - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  splitStrobes_t    strobes,
  input  logic [1:0]       instMode,
  input  logic [NF_W-1:0]  instNfm1,
  input  logic [MUL_W-1:0] instLmulLog2,
  input  logic [MUL_W-1:0] instEmulLog2,
  input  logic [REG_W-1:0] instVd,
  input  logic [REG_W-1:0] instRs1,
  input  logic [REG_W-1:0] instRs2,
  input  logic [REG_W-1:0] instVs2,
  output logic             isLast,
  output logic [IDX_W-1:0] uopIdx,
  output logic [REG_W-1:0] uopDest,
  output logic [REG_W-1:0] uopBaseReg,
  output logic             uopBaseValid,
  output logic [REG_W-1:0] uopOffReg,
  output logic             uopOffValid
);

  splitMode_e       modeR;
  logic [NF_W-1:0]  nfm1R;
  logic [MUL_W-1:0] lmulR, emulR;
  logic [REG_W-1:0] vdR, rs1R, rs2R, vs2R;
  logic [IDX_W-1:0] idxR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeR <= MODE_UNIT;
      nfm1R <= '0;
      lmulR <= '0;
      emulR <= '0;
      vdR   <= '0;
      rs1R  <= '0;
      rs2R  <= '0;
      vs2R  <= '0;
      idxR  <= '0;
    end else if (strobes.load) begin
      modeR <= splitMode_e'(instMode);
      nfm1R <= instNfm1;
      lmulR <= instLmulLog2;
      emulR <= instEmulLog2;
      vdR   <= instVd;
      rs1R  <= instRs1;
      rs2R  <= instRs2;
      vs2R  <= instVs2;
      idxR  <= '0;
    end else if (strobes.advance) begin
      idxR <= idxR + 1'b1;
    end
  end

  // uop count per mode
  logic [CNT_W-1:0] nfCnt, emulCnt, groupCnt, strideTotal, indexTotal, total;
  logic             indexed;

  always_comb begin
    indexed     = (modeR == MODE_INDEXED);
    nfCnt       = CNT_W'(nfm1R) + 1'b1;
    emulCnt     = CNT_W'(1) << emulR;
    groupCnt    = nfCnt << lmulR;
    strideTotal = nfCnt << emulR;
    indexTotal  = (groupCnt > emulCnt) ? groupCnt : emulCnt;
    total       = indexed ? indexTotal : strideTotal;
  end

  logic [CNT_W-1:0] idxWide;
  logic             offInRange;
  assign idxWide    = CNT_W'(idxR);
  assign offInRange = (idxWide < emulCnt);
  assign isLast     = (idxWide == total - 1'b1);

  // per-uop fields
  always_comb begin
    uopIdx  = idxR;
    uopDest = vdR + REG_W'(idxR);
    if (indexed) begin
      uopBaseValid = (idxR == '0);
      uopBaseReg   = uopBaseValid ? rs1R : '0;
      uopOffValid  = offInRange;
      uopOffReg    = offInRange ? (vs2R + REG_W'(idxR)) : '0;
    end else begin
      uopBaseValid = 1'b1;
      uopBaseReg   = rs1R;
      uopOffValid  = 1'b1;
      uopOffReg    = rs2R;
    end
  end

endmodule

// File: rtl/segUopSplitter.sv
module segUopSplitter
  import segSplitPkg::*;
#(
  parameter int REG_W = 5,
  parameter int NF_W  = 3,
  parameter int MUL_W = 2,
  localparam int CNT_W = NF_W + 1 + (2**MUL_W - 1),
  localparam int IDX_W = CNT_W - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instValid,
  output logic             instReady,
  input  logic [1:0]       instMode,
  input  logic [NF_W-1:0]  instNfm1,
  input  logic [MUL_W-1:0] instLmulLog2,
  input  logic [MUL_W-1:0] instEmulLog2,
  input  logic [REG_W-1:0] instVd,
  input  logic [REG_W-1:0] instRs1,
  input  logic [REG_W-1:0] instRs2,
  input  logic [REG_W-1:0] instVs2,
  output logic             uopValid,
  input  logic             uopReady,
  output logic [IDX_W-1:0] uopIdx,
  output logic [REG_W-1:0] uopDest,
  output logic [REG_W-1:0] uopBaseReg,
  output logic             uopBaseValid,
  output logic [REG_W-1:0] uopOffReg,
  output logic             uopOffValid,
  output logic             uopLast
);

  splitStrobes_t strobes;
  logic          isLast;

  segSplitCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid),
    .uopReady  (uopReady),
    .isLast    (isLast),
    .instReady (instReady),
    .uopValid  (uopValid),
    .strobes   (strobes)
  );

  segSplitDatapath #(.REG_W(REG_W), .NF_W(NF_W), .MUL_W(MUL_W)) uData (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .instMode     (instMode),
    .instNfm1     (instNfm1),
    .instLmulLog2 (instLmulLog2),
    .instEmulLog2 (instEmulLog2),
    .instVd       (instVd),
    .instRs1      (instRs1),
    .instRs2      (instRs2),
    .instVs2      (instVs2),
    .isLast       (isLast),
    .uopIdx       (uopIdx),
    .uopDest      (uopDest),
    .uopBaseReg   (uopBaseReg),
    .uopBaseValid (uopBaseValid),
    .uopOffReg    (uopOffReg),
    .uopOffValid  (uopOffValid)
  );

  assign uopLast = uopValid & isLast;

endmodule

// File: rtl/segSplitCheck.sv
module segSplitCheck #(
  parameter int REG_W = 5,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             instValid,
  input logic             instReady,
  input logic             uopValid,
  input logic             uopReady,
  input logic [IDX_W-1:0] uopIdx,
  input logic [REG_W-1:0] uopDest,
  input logic [REG_W-1:0] uopBaseReg,
  input logic             uopBaseValid,
  input logic [REG_W-1:0] uopOffReg,
  input logic             uopOffValid,
  input logic             uopLast
);

  p_ready_only_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    instReady |-> !uopValid);

  p_first_uop_r2: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instReady) |=> (uopValid && uopIdx == '0));

  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rstN)
    (uopValid && !uopReady) |=> (uopValid && $stable(uopIdx) && $stable(uopDest)
      && $stable(uopBaseReg) && $stable(uopOffReg) && $stable(uopLast)));

  p_done_after_last_r10: assert property (@(posedge clk) disable iff (!rstN)
    (uopValid && uopReady && uopLast) |=> (!uopValid && instReady));

  p_idx_step_r11: assert property (@(posedge clk) disable iff (!rstN)
    (uopValid && uopReady && !uopLast) |=> (uopValid && uopIdx == $past(uopIdx) + 1'b1));

  p_later_base_r7: assert property (@(posedge clk) disable iff (!rstN)
    (uopValid && !uopBaseValid) |-> (uopIdx != '0 && uopBaseReg == '0));

endmodule

bind segUopSplitter segSplitCheck #(.REG_W(REG_W), .IDX_W(IDX_W)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .instValid    (instValid),
  .instReady    (instReady),
  .uopValid     (uopValid),
  .uopReady     (uopReady),
  .uopIdx       (uopIdx),
  .uopDest      (uopDest),
  .uopBaseReg   (uopBaseReg),
  .uopBaseValid (uopBaseValid),
  .uopOffReg    (uopOffReg),
  .uopOffValid  (uopOffValid),
  .uopLast      (uopLast)
);

// File: tb/segUopSplitter_test.sv
module segUopSplitter_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       instValid = 1'b0;
  logic       instReady;
  logic [1:0] instMode = '0;
  logic [2:0] instNfm1 = '0;
  logic [1:0] instLmulLog2 = '0;
  logic [1:0] instEmulLog2 = '0;
  logic [4:0] instVd = '0, instRs1 = '0, instRs2 = '0, instVs2 = '0;
  logic       uopValid;
  logic       uopReady = 1'b0;
  logic [5:0] uopIdx;
  logic [4:0] uopDest, uopBaseReg, uopOffReg;
  logic       uopBaseValid, uopOffValid, uopLast;

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  segUopSplitter uut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instReady(instReady),
    .instMode(instMode), .instNfm1(instNfm1), .instLmulLog2(instLmulLog2),
    .instEmulLog2(instEmulLog2), .instVd(instVd), .instRs1(instRs1),
    .instRs2(instRs2), .instVs2(instVs2), .uopValid(uopValid),
    .uopReady(uopReady), .uopIdx(uopIdx), .uopDest(uopDest),
    .uopBaseReg(uopBaseReg), .uopBaseValid(uopBaseValid),
    .uopOffReg(uopOffReg), .uopOffValid(uopOffValid), .uopLast(uopLast)
  );

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  int wdog = 0;
  always @(posedge clk) begin
    wdog++;
    if (wdog > 100000) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=%0d expected=%0d", wdog, 100000);
      summary();
    end
  end

  // {mode[1:0], nfm1[2:0], lmulLog2[1:0], emulLog2[1:0], count[6:0]}
  localparam int NVEC = 10;
  localparam logic [15:0] VECS [NVEC] = '{
    {2'd0, 3'd1, 2'd0, 2'd0, 7'd2},   // R3 unit nf2 emul1
    {2'd1, 3'd3, 2'd0, 2'd1, 7'd8},   // R3 strided nf4 emul2
    {2'd2, 3'd1, 2'd1, 2'd2, 7'd4},   // R4 tie 4 vs 4
    {2'd2, 3'd2, 2'd0, 2'd1, 7'd3},   // R4 nf3 emul2, third offset don't-care
    {2'd2, 3'd7, 2'd0, 2'd3, 7'd8},   // R4 nf8 emul8
    {2'd2, 3'd0, 2'd0, 2'd3, 7'd8},   // R4 emul wins
    {2'd2, 3'd7, 2'd3, 2'd0, 7'd64},  // R4 max count, group wins
    {2'd1, 3'd7, 2'd0, 2'd3, 7'd64},  // R3 max strided count
    {2'd3, 3'd0, 2'd0, 2'd0, 7'd1},   // R3 mode 3 single uop
    {2'd0, 3'd4, 2'd2, 2'd1, 7'd10}   // R3 unit nf5 emul2
  };

  task automatic runVec(logic [15:0] v, logic [4:0] vd, logic [4:0] rs1,
                        logic [4:0] rs2, logic [4:0] vs2, bit stall, bit noise);
    logic [1:0] md   = v[15:14];
    logic [1:0] emL  = v[8:7];
    int         cnt  = int'(v[6:0]);
    int         n    = 0;
    int         cyc  = 0;
    bit         done = 0;
    string      cntTag = (md == 2'd2) ? "R4 count" : "R3 count";
    @(negedge clk);
    chk(instReady === 1'b1, "R2 ready before issue", instReady, 1);
    instValid = 1'b1;
    instMode = md; instNfm1 = v[13:11]; instLmulLog2 = v[10:9]; instEmulLog2 = emL;
    instVd = vd; instRs1 = rs1; instRs2 = rs2; instVs2 = vs2;
    @(negedge clk);
    instValid = noise;
    if (noise) begin
      instMode = ~md; instNfm1 = ~v[13:11]; instVd = ~vd;
      instRs1 = ~rs1; instRs2 = ~rs2; instVs2 = ~vs2;
    end
    chk(uopValid === 1'b1 && uopIdx === 6'd0, "R2 first uop", uopIdx, 0);
    while (!done) begin
      uopReady = stall ? (cyc % 3 != 1) : 1'b1;
      if (!uopValid) begin
        chk(0, "R10 valid dropped early", n, cnt);
        done = 1;
      end else begin
        chk(uopIdx === 6'(n), "R11 R9 index", uopIdx, n);
        if (noise) chk(instReady === 1'b0, "R2 busy not ready", instReady, 0);
        if (uopReady) begin
          logic [4:0] eDest = vd + 5'(n);
          logic       eBv, eOv;
          logic [4:0] eB, eO;
          if (md == 2'd2) begin
            eBv = (n == 0);
            eB  = eBv ? rs1 : 5'd0;
            eOv = (n < (1 << emL));
            eO  = eOv ? vs2 + 5'(n) : 5'd0;
          end else begin
            eBv = 1'b1; eB = rs1; eOv = 1'b1; eO = rs2;
          end
          chk(uopDest === eDest, "R5 dest", uopDest, eDest);
          chk({uopBaseValid, uopBaseReg, uopOffValid, uopOffReg} === {eBv, eB, eOv, eO},
              (md == 2'd2) ? "R7 R8 base/offset" : "R6 base/offset",
              {uopBaseValid, uopBaseReg, uopOffValid, uopOffReg}, {eBv, eB, eOv, eO});
          chk(uopLast === (n == cnt - 1), "R10 last flag", uopLast, (n == cnt - 1));
          n++;
          if (uopLast) done = 1;
        end
      end
      cyc++;
      @(negedge clk);
    end
    uopReady = 1'b0;
    instValid = 1'b0;
    chk(uopValid === 1'b0 && instReady === 1'b1, "R10 idle after last",
        {uopValid, instReady}, 2'b01);
    chk(n == cnt, cntTag, n, cnt);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(uopValid === 1'b0 && instReady === 1'b1, "R1 in reset", {uopValid, instReady}, 2'b01);
    rstN = 1'b1;
    @(negedge clk);
    chk(uopValid === 1'b0 && instReady === 1'b1, "R1 after reset", {uopValid, instReady}, 2'b01);

    for (int k = 0; k < NVEC; k++) begin
      runVec(VECS[k], 5'(20 + 3 * k), 5'(k + 1), 5'(9 + k), 5'(26 + k), k[0], 1'b0);
    end

    // directed: stalls with noisy instruction offers while busy (R2, R9)
    runVec({2'd2, 3'd2, 2'd0, 2'd1, 7'd3}, 5'd30, 5'd4, 5'd5, 5'd31, 1'b1, 1'b1);
    runVec({2'd1, 3'd1, 2'd1, 2'd1, 7'd4}, 5'd31, 5'd7, 5'd8, 5'd2, 1'b1, 1'b1);

    // directed: consumer holds off for several cycles, output must hold (R9)
    @(negedge clk);
    instValid = 1'b1; instMode = 2'd2; instNfm1 = 3'd0; instLmulLog2 = 2'd0;
    instEmulLog2 = 2'd1; instVd = 5'd3; instRs1 = 5'd1; instRs2 = 5'd2; instVs2 = 5'd6;
    @(negedge clk);
    instValid = 1'b0;
    uopReady = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(uopValid === 1'b1 && uopIdx === 6'd0 && uopDest === 5'd3,
          "R9 hold while stalled", {uopValid, uopIdx, uopDest}, {1'b1, 6'd0, 5'd3});
    end
    uopReady = 1'b1;
    @(negedge clk);
    chk(uopIdx === 6'd1 && uopOffReg === 5'd7 && uopBaseValid === 1'b0,
        "R8 second indexed uop", {uopIdx, uopOffReg, uopBaseValid}, {6'd1, 5'd7, 1'b0});
    chk(uopLast === 1'b1, "R4 emul wins last", uopLast, 1);
    @(negedge clk);
    uopReady = 1'b0;
    chk(uopValid === 1'b0, "R10 done", uopValid, 0);

    // directed: reset in the middle of a sequence (R1)
    @(negedge clk);
    instValid = 1'b1; instMode = 2'd1; instNfm1 = 3'd7; instEmulLog2 = 2'd3;
    @(negedge clk);
    instValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    chk(uopValid === 1'b0 && instReady === 1'b1, "R1 mid-run reset", {uopValid, instReady}, 2'b01);
    rstN = 1'b1;
    @(negedge clk);

    summary();
  end

endmodule